// File: doc/BRIEF.md
# Event Performance Counter Bank

This block holds a parameterised set of event counters that a processor core uses to measure what its pipeline does. Event sources arrive as a flat vector of groups. Each group carries a set of sub-event bits. Each counter picks one group and a sub-event mask. It adds one on every clock in which any masked bit of that group is high, provided the bank is enabled and the privilege and trace-level filters pass.

Software programs and inspects the bank through a plain single-cycle register port. There is one global register, and each counter has a value register, a control register and a status register. Counters may be preloaded with any value, so a negative preload produces an overflow after a chosen number of events. A chaining select code lets a counter count the wraps of its lower neighbour, which builds a wider count. Overflows are latched per counter, cleared by writing ones, and drive one shared level interrupt.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register map, byte offsets on a 9-bit address with bits 1:0 zero: global at 0x000 (bit 0 is the enable, other bits read 0); value i at 0x080+4i; control i at 0x100+4i; status i at 0x180+4i; any other address reads 0. The control word keeps only these fields: interrupt enable bit 0, kernel-count bit 3, trace level bits 7:4, group select bits 12:8 and sub-event mask bits 31:16. All other control bits read 0.
- R3: While global bit 0 is 0, no counter changes except by a software write.
- R4: With select g (g not 1), a counter adds exactly one on a clock where `evt_in[16g+15:16g]` ANDed with its mask is nonzero, and holds otherwise.
- R5: While `kern_mode` is 1, a counter with control bit 3 clear does not count; with bit 3 set it counts.
- R6: A counter does not count while `trace_lvl` is below its programmed level (bits 7:4).
- R7: With select 1, counter i (i>0) adds one exactly on the clocks in which counter i-1 wraps; counter 0 with select 1 never counts.
- R8: An increment from all ones wraps the value to 0. In the same clock it sets status bit 0, and counting continues from 0.
- R9: Writing status with bit 0 set clears the overflow flag, and writing 0 there has no effect. A wrap in the same clock wins over the clear. Status bit 4 reads as overflow AND interrupt enable.
- R10: `irq` is high exactly while some counter has both its overflow flag and its interrupt enable set.
- R11: A write to a value register in the same clock as an increment loads the written value, and that clock sets no overflow.
- R12: A counter whose control register is written with 0 stops counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 9 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| evt_in | input | NUM_GRP*16 | Event groups, 16 sub-event bits each |
| kern_mode | input | 1 | Core is running in kernel mode |
| trace_lvl | input | 4 | Current trace level |
| irq | output | 1 | Level interrupt, OR of enabled overflows |

## Verification
On every cycle, assertions inside each counter slice check four things. The global enable and a zero control word freeze the value. A value changes by at most one step. A wrap latches the overflow. A write wins over an increment and over the overflow clear. Select decoding, the kernel and trace filters, chaining across neighbours, readback masking and the shared interrupt can only be shown by the bench scenarios. There, a behavioural model of the register map is compared with `rdata` and `irq` on every clock, under directed cases and a randomised mix of events and writes.

// File: rtl/evt_ctr_pkg.sv
`timescale 1ns/1ps
package evt_ctr_pkg;
   localparam int REG_W   = 32;
   localparam int SEL_W   = 5;
   localparam int MASK_W  = 16;
   localparam int LVL_W   = 4;
   localparam int ADDR_W  = 9;

   localparam logic [1:0] KIND_GLB = 2'd0;
   localparam logic [1:0] KIND_VAL = 2'd1;
   localparam logic [1:0] KIND_CTL = 2'd2;
   localparam logic [1:0] KIND_STS = 2'd3;

   localparam logic [SEL_W-1:0] SEL_CHAIN = 5'd1;

   localparam int STS_OVF_BIT = 0;
   localparam int STS_IRQ_BIT = 4;

   typedef struct packed {
      logic [MASK_W-1:0] mask;
      logic [SEL_W-1:0]  sel;
      logic [LVL_W-1:0]  lvl;
      logic              krn;
      logic              ie;
   } ctl_t;

   function automatic logic [REG_W-1:0] ctl_to_word(ctl_t c);
      return {c.mask, 3'b000, c.sel, c.lvl, c.krn, 2'b00, c.ie};
   endfunction

   function automatic ctl_t word_to_ctl(logic [REG_W-1:0] w);
      ctl_t c;
      c.mask = w[31:16];
      c.sel  = w[12:8];
      c.lvl  = w[7:4];
      c.krn  = w[3];
      c.ie   = w[0];
      return c;
   endfunction
endpackage

// File: rtl/evt_ctr_gate.sv
`timescale 1ns/1ps
module evt_ctr_gate
   import evt_ctr_pkg::*;
#(
   parameter int NUM_GRP  = 32,
   parameter bit HAS_PREV = 1'b1
) (
   input  logic                      glb_en,
   input  logic [NUM_GRP*MASK_W-1:0] evt_in,
   input  logic                      kern_mode,
   input  logic [LVL_W-1:0]          trace_lvl,
   input  ctl_t                      ctl,
   input  logic                      prev_wrap,
   output logic                      fire
);
   logic [MASK_W-1:0] grp_bits;
   logic              chain_hit;
   logic              filt_ok;
   logic              evt_hit;

   always_comb begin
      grp_bits = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (ctl.sel == SEL_W'(g)) grp_bits = evt_in[g*MASK_W +: MASK_W];
      end
   end

   generate
      if (HAS_PREV) begin : g_chain
         assign chain_hit = prev_wrap;
      end else begin : g_nochain
         logic unused_prev;
         assign unused_prev = prev_wrap;
         assign chain_hit   = 1'b0;
      end
   endgenerate

   assign filt_ok = (!kern_mode || ctl.krn) && (trace_lvl >= ctl.lvl);
   assign evt_hit = (|(grp_bits & ctl.mask)) && filt_ok;
   assign fire    = glb_en && ((ctl.sel == SEL_CHAIN) ? chain_hit : evt_hit);
endmodule

// File: rtl/evt_ctr_slice.sv
`timescale 1ns/1ps
module evt_ctr_slice
   import evt_ctr_pkg::*;
#(
   parameter int CTR_W    = 32,
   parameter int NUM_GRP  = 32,
   parameter bit HAS_PREV = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      glb_en,
   input  logic [NUM_GRP*MASK_W-1:0] evt_in,
   input  logic                      kern_mode,
   input  logic [LVL_W-1:0]          trace_lvl,
   input  logic                      prev_wrap,
   input  logic                      val_we,
   input  logic                      ctl_we,
   input  logic                      sts_we,
   input  logic [REG_W-1:0]          wdata,
   output logic [CTR_W-1:0]          cnt_q,
   output logic [REG_W-1:0]          ctl_word,
   output logic [REG_W-1:0]          sts_word,
   output logic                      wrap,
   output logic                      irq_o
);
   ctl_t ctl_q;
   logic ovf_q;
   logic fire;

   evt_ctr_gate #(.NUM_GRP(NUM_GRP), .HAS_PREV(HAS_PREV)) u_gate (
      .glb_en    (glb_en),
      .evt_in    (evt_in),
      .kern_mode (kern_mode),
      .trace_lvl (trace_lvl),
      .ctl       (ctl_q),
      .prev_wrap (prev_wrap),
      .fire      (fire)
   );

   assign wrap = fire && (&cnt_q) && !val_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ctl_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (val_we)     cnt_q <= wdata[CTR_W-1:0];
         else if (fire)  cnt_q <= cnt_q + 1'b1;
         if (ctl_we)     ctl_q <= word_to_ctl(wdata);
         ovf_q <= wrap || (ovf_q && !(sts_we && wdata[STS_OVF_BIT]));
      end
   end

   assign irq_o    = ovf_q && ctl_q.ie;
   assign ctl_word = ctl_to_word(ctl_q);

   always_comb begin
      sts_word              = '0;
      sts_word[STS_OVF_BIT] = ovf_q;
      sts_word[STS_IRQ_BIT] = irq_o;
   end

   // R3
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en && !val_we) |=> $stable(cnt_q));
   // R4
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !val_we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
   // R8
   wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (&cnt_q) && !val_we) |=> (ovf_q && cnt_q == '0));
   // R9
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we && wdata[STS_OVF_BIT] && !wrap) |=> !ovf_q);
   // R11
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      val_we |=> (cnt_q == $past(wdata[CTR_W-1:0]) && ovf_q == $past(ovf_q && !(sts_we && wdata[STS_OVF_BIT]))));
   // R12
   stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_word == '0 && !val_we) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_ctr_regif.sv
`timescale 1ns/1ps
module evt_ctr_regif
   import evt_ctr_pkg::*;
#(
   parameter int NUM_CTR = 4,
   parameter int CTR_W   = 32
) (
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [REG_W-1:0]         wdata,
   input  logic                     glb_q,
   input  logic [NUM_CTR*CTR_W-1:0] val_all,
   input  logic [NUM_CTR*REG_W-1:0] ctl_all,
   input  logic [NUM_CTR*REG_W-1:0] sts_all,
   output logic                     glb_we,
   output logic [NUM_CTR-1:0]       val_we,
   output logic [NUM_CTR-1:0]       ctl_we,
   output logic [NUM_CTR-1:0]       sts_we,
   output logic [REG_W-1:0]         rdata
);
   localparam logic [5:0] NUM_LIM = NUM_CTR[5:0];

   logic [1:0] kind;
   logic [4:0] idx;
   logic       aligned;
   logic       in_bank;
   logic       unused_wd;

   assign kind      = addr[8:7];
   assign idx       = addr[6:2];
   assign aligned   = (addr[1:0] == 2'b00);
   assign in_bank   = aligned && ({1'b0, idx} < NUM_LIM);
   assign glb_we    = wr_en && aligned && kind == KIND_GLB && idx == 5'd0;
   assign unused_wd = ^wdata;

   generate
      for (genvar i = 0; i < NUM_CTR; i++) begin : g_dec
         localparam logic [4:0] IDX = 5'(i);
         assign val_we[i] = wr_en && in_bank && kind == KIND_VAL && idx == IDX;
         assign ctl_we[i] = wr_en && in_bank && kind == KIND_CTL && idx == IDX;
         assign sts_we[i] = wr_en && in_bank && kind == KIND_STS && idx == IDX;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      unique case (kind)
         KIND_GLB: if (aligned && idx == 5'd0) rdata[0] = glb_q;
         KIND_VAL: if (in_bank) rdata[CTR_W-1:0] = val_all[idx*CTR_W +: CTR_W];
         KIND_CTL: if (in_bank) rdata = ctl_all[idx*REG_W +: REG_W];
         KIND_STS: if (in_bank) rdata = sts_all[idx*REG_W +: REG_W];
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/evt_ctr_bank.sv
`timescale 1ns/1ps
module evt_ctr_bank
   import evt_ctr_pkg::*;
#(
   parameter int NUM_CTR = 4,
   parameter int CTR_W   = 32,
   parameter int NUM_GRP = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [8:0]                addr,
   input  logic [31:0]               wdata,
   output logic [31:0]               rdata,
   input  logic [NUM_GRP*16-1:0]     evt_in,
   input  logic                      kern_mode,
   input  logic [3:0]                trace_lvl,
   output logic                      irq
);
   generate
      if (NUM_CTR < 1 || NUM_CTR > 32) begin : g_bad_num
         $error("NUM_CTR must lie in 1..32");
      end
      if (CTR_W < 8 || CTR_W > REG_W) begin : g_bad_w
         $error("CTR_W must lie in 8..32");
      end
      if (NUM_GRP < 2 || NUM_GRP > 32) begin : g_bad_grp
         $error("NUM_GRP must lie in 2..32");
      end
   endgenerate

   logic                     glb_q;
   logic                     glb_we;
   logic [NUM_CTR-1:0]       val_we, ctl_we, sts_we;
   logic [NUM_CTR-1:0]       wrap_v, irq_v;
   logic [NUM_CTR*CTR_W-1:0] val_all;
   logic [NUM_CTR*REG_W-1:0] ctl_all, sts_all;

   always_ff @(posedge clk) begin
      if (!rst_n)      glb_q <= 1'b0;
      else if (glb_we) glb_q <= wdata[0];
   end

   evt_ctr_regif #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_regif (
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .glb_q   (glb_q),
      .val_all (val_all),
      .ctl_all (ctl_all),
      .sts_all (sts_all),
      .glb_we  (glb_we),
      .val_we  (val_we),
      .ctl_we  (ctl_we),
      .sts_we  (sts_we),
      .rdata   (rdata)
   );

   generate
      for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
         logic prev_w;
         if (i == 0) begin : g_first
            assign prev_w = 1'b0;
         end else begin : g_rest
            assign prev_w = wrap_v[i-1];
         end
         evt_ctr_slice #(
            .CTR_W    (CTR_W),
            .NUM_GRP  (NUM_GRP),
            .HAS_PREV (i != 0)
         ) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .glb_en    (glb_q),
            .evt_in    (evt_in),
            .kern_mode (kern_mode),
            .trace_lvl (trace_lvl),
            .prev_wrap (prev_w),
            .val_we    (val_we[i]),
            .ctl_we    (ctl_we[i]),
            .sts_we    (sts_we[i]),
            .wdata     (wdata),
            .cnt_q     (val_all[i*CTR_W +: CTR_W]),
            .ctl_word  (ctl_all[i*REG_W +: REG_W]),
            .sts_word  (sts_all[i*REG_W +: REG_W]),
            .wrap      (wrap_v[i]),
            .irq_o     (irq_v[i])
         );
      end
   endgenerate

   assign irq = |irq_v;

   // R10
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq == 1'b0) |-> (irq_v == '0));
endmodule

// File: tb/evt_ctr_bank_tb.sv
`timescale 1ns/1ps
module evt_ctr_bank_tb;
   localparam int N = 4;
   localparam int G = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en;
   logic [8:0]    addr;
   logic [31:0]   wdata;
   logic [G*16-1:0] evt;
   logic          kern;
   logic [3:0]    tlv;
   wire  [31:0]   rdata;
   wire           irq;

   int    vectors = 0;
   int    errors  = 0;
   bit    done    = 1'b0;
   string cur_req = "R1";

   logic [31:0] m_cnt [N];
   logic [31:0] m_ctl [N];
   logic        m_ovf [N];
   logic        m_glb;

   always #10 clk = ~clk;

   evt_ctr_bank #(.NUM_CTR(N), .CTR_W(32), .NUM_GRP(G)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .evt_in(evt), .kern_mode(kern), .trace_lvl(tlv), .irq(irq)
   );

   // behavioural reference model, updated on the same edge as the design
   always @(posedge clk) begin : model
      logic pw, fire, vw, wr;
      logic [4:0] sel;
      logic [15:0] grp;
      if (!rst_n) begin
         m_glb = 1'b0;
         for (int i = 0; i < N; i++) begin
            m_cnt[i] = '0; m_ctl[i] = '0; m_ovf[i] = 1'b0;
         end
      end else begin
         pw = 1'b0;
         for (int i = 0; i < N; i++) begin
            sel  = m_ctl[i][12:8];
            grp  = 16'(evt >> (int'(sel) * 16));
            fire = 1'b0;
            if (m_glb) begin
               if (sel == 5'd1) fire = (i > 0) && pw;
               else fire = ((grp & m_ctl[i][31:16]) != 0) &&
                           (!kern || m_ctl[i][3]) && (tlv >= m_ctl[i][7:4]);
            end
            vw = wr_en && (addr == 9'(128 + 4*i));
            wr = fire && (m_cnt[i] == 32'hFFFF_FFFF) && !vw;
            if (vw) m_cnt[i] = wdata;
            else if (fire) m_cnt[i] = m_cnt[i] + 1;
            m_ovf[i] = wr || (m_ovf[i] && !(wr_en && addr == 9'(384 + 4*i) && wdata[0]));
            pw = wr;
         end
         for (int i = 0; i < N; i++)
            if (wr_en && addr == 9'(256 + 4*i)) m_ctl[i] = wdata & 32'hFFFF_1FF9;
         if (wr_en && addr == 9'd0) m_glb = wdata[0];
      end
   end

   function automatic logic [31:0] m_read(logic [8:0] a);
      logic [31:0] r = '0;
      if (a == 9'd0) r = {31'b0, m_glb};
      for (int i = 0; i < N; i++) begin
         if (a == 9'(128 + 4*i)) r = m_cnt[i];
         if (a == 9'(256 + 4*i)) r = m_ctl[i];
         if (a == 9'(384 + 4*i)) r = {27'b0, m_ovf[i] & m_ctl[i][0], 3'b0, m_ovf[i]};
      end
      return r;
   endfunction

   function automatic logic m_irq();
      logic r = 1'b0;
      for (int i = 0; i < N; i++) r |= m_ovf[i] & m_ctl[i][0];
      return r;
   endfunction

   // compare on every falling edge, away from the active edge
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         vectors++;
         if (rdata !== m_read(addr)) begin
            errors++;
            $display("FAIL %s rdata addr=%h act=%h exp=%h", cur_req, addr, rdata, m_read(addr));
         end
         if (irq !== m_irq()) begin
            errors++;
            $display("FAIL %s irq act=%b exp=%b", cur_req, irq, m_irq());
         end
      end
   end

   task automatic cyc(int n = 1);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(logic [8:0] a, logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [8:0] a, int n = 1);
      addr = a;
      cyc(n);
   endtask

   task automatic set_grp(int g, logic [15:0] v);
      evt[g*16 +: 16] = v;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; evt = '0; kern = 1'b0; tlv = '0;
      cyc(3);
      rst_n = 1'b1;

      // R1: reset state of every register
      cur_req = "R1";
      rd(9'h000);
      for (int i = 0; i < N; i++) begin
         rd(9'(128 + 4*i)); rd(9'(256 + 4*i)); rd(9'(384 + 4*i));
      end

      // R2: readback masking and unmapped addresses
      cur_req = "R2";
      wr(9'h100, 32'hFFFF_FFFF); rd(9'h100);
      wr(9'h100, 32'h0000_0000); rd(9'h100);
      wr(9'h000, 32'h0000_00FE); rd(9'h000);
      rd(9'h002); rd(9'h190); rd(9'h07C);

      // R3: events present, bank disabled
      cur_req = "R3";
      wr(9'h100, 32'h0003_0500);
      set_grp(5, 16'h0001);
      rd(9'h080, 5);

      // R4: group select and mask patterns
      cur_req = "R4";
      wr(9'h000, 32'h1);
      wr(9'h104, 32'h8000_0200);
      rd(9'h080, 3);
      set_grp(5, 16'h0004); rd(9'h080, 3);
      set_grp(5, 16'h0002); set_grp(2, 16'h8000); rd(9'h084, 4);
      set_grp(2, 16'h7FFF); rd(9'h084, 3);
      set_grp(3, 16'hFFFF); rd(9'h080, 2);

      // R5: kernel-mode filter
      cur_req = "R5";
      wr(9'h108, 32'h0001_0308);
      set_grp(3, 16'h0001); kern = 1'b1;
      rd(9'h080, 3); rd(9'h088, 3);
      kern = 1'b0; rd(9'h080, 2);

      // R6: trace-level filter
      cur_req = "R6";
      wr(9'h10C, 32'h0001_0350);
      tlv = 4'd3; rd(9'h08C, 3);
      tlv = 4'd5; rd(9'h08C, 2);
      tlv = 4'd7; rd(9'h08C, 2);
      tlv = 4'd0;

      // R7: chaining to the lower neighbour
      cur_req = "R7";
      wr(9'h100, 32'h0001_0500); set_grp(5, 16'h0001);
      wr(9'h104, 32'h0000_0100);
      wr(9'h080, 32'hFFFF_FFFD);
      rd(9'h084, 5);
      wr(9'h100, 32'h0000_0100); rd(9'h080, 3);

      // R8 / R10: wrap, overflow flag, interrupt
      cur_req = "R8";
      wr(9'h108, 32'h0001_0309);
      wr(9'h088, 32'hFFFF_FFFE);
      rd(9'h188, 2); rd(9'h088, 3);
      cur_req = "R10";
      rd(9'h188, 2);
      wr(9'h108, 32'h0001_0308); rd(9'h188, 2);
      wr(9'h108, 32'h0001_0309); rd(9'h188, 2);

      // R9: write-one-to-clear, zero write ignored, wrap beats clear
      cur_req = "R9";
      wr(9'h188, 32'h0000_0010); rd(9'h188, 2);
      wr(9'h188, 32'h0000_0011); rd(9'h188, 2);
      wr(9'h088, 32'hFFFF_FFFF);
      wr(9'h188, 32'h0000_0001); rd(9'h188, 2);
      wr(9'h188, 32'h0000_0001); rd(9'h188, 2);

      // R11: write beats increment at the wrap point
      cur_req = "R11";
      wr(9'h088, 32'hFFFF_FFFF);
      wr(9'h088, 32'h0000_1234); rd(9'h188, 1); rd(9'h088, 2);

      // R12: zeroing the control stops the counter
      cur_req = "R12";
      wr(9'h108, 32'h0);
      rd(9'h088, 4); rd(9'h188, 1);

      // mixed random phase over all requirements (R4 R7 R8 R9 R11)
      cur_req = "R4";
      for (int k = 0; k < 3000; k++) begin
         int sel_a;
         logic [8:0] a;
         evt  = {16{$urandom()}} & {16{$urandom()}};
         kern = 1'($urandom());
         tlv  = 4'($urandom());
         sel_a = int'($urandom_range(0, 3));
         a = (sel_a == 0) ? 9'h000 : 9'((sel_a * 128) + 4 * int'($urandom_range(0, N-1)));
         if ($urandom_range(0, 7) == 0) begin
            if (sel_a == 1)      wr(a, 32'hFFFF_FFF0 | 32'($urandom_range(0, 15)));
            else if (sel_a == 0) wr(a, 32'h1);
            else                 wr(a, $urandom());
         end else begin
            rd(9'((int'($urandom_range(0, 3)) * 128) + 4 * int'($urandom_range(0, N-1))));
         end
      end

      cyc(2);
      finish_run();
   end
endmodule